// File: doc/BRIEF.md
# Programmable Divider and Timer Counter

This block keeps time for a small processor subsystem. An 8-bit divider runs on every enabled input cycle. A second 8-bit counter advances once every N enabled cycles, where N comes from a control register. When that counter passes 0xFF, it reloads from a modulo register and emits a one-cycle interrupt request. The `tick_en` input qualifies each clock as one input cycle.

Software reaches the four registers through a plain single-cycle write port and a combinational read port, both selected by a 2-bit offset. Offset 0 is the divider, 1 is the counter, 2 is the modulo value and 3 is the control. Writes take effect at the next clock edge and are never refused, so the port has no handshake. The interrupt output is a plain pulse, not a stream.

Top module: `tick_timer`

## Requirements
- R1: After reset, the divider, counter, modulo and control registers all read 0x00, and `irq_pulse` is low.
- R2: Every clock with `tick_en` high adds one to the divider, which wraps from 0xFF to 0x00. The divider holds when `tick_en` is low.
- R3: A write to offset 0 sets the divider to 0x00 whatever the data, and takes precedence over a same-cycle increment.
- R4: Control bit 2 is the run enable. While it is 0, neither the counter nor the prescale count moves.
- R5: Control bits 1:0 select the counter period in enabled input cycles: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256.
- R6: The prescale count restarts at zero on the tick that increments the counter. This happens once the count has reached the selected period minus one or more. After a switch to a shorter period, the next running tick therefore increments the counter.
- R7: An increment from 0xFF loads the counter with the modulo value held before that edge. `irq_pulse` is then high for exactly the one following cycle.
- R8: A write to offset 1 loads the counter with the data and wins over a same-cycle increment. That cycle produces no interrupt.
- R9: `rd_data` shows the register at `rd_addr` combinationally. The control register appears in bits 2:0 with bits 7:3 read as zero.
- R10: Writes to the control register or to the divider leave the prescale count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Marks this clock as one input cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write offset (0 divider, 1 counter, 2 modulo, 3 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read offset, same map as writes |
| rd_data | output | 8 | Readback of the selected register |
| irq_pulse | output | 1 | One-cycle timer interrupt request |

## Verification
The first pattern is a directed sequence from reset at the 16-cycle rate, which places the overflow, the reload value and the interrupt cycle exactly. Next come a disabled window and one full 1024-cycle period, which separate holding from counting and tell one period setting from another. A switch from a long period to a short one in mid-count exposes the at-or-past wrap rule. A counter write on an increment tick exposes write precedence. A long random phase then mixes writes to every offset with gaps in `tick_en`, compared every clock against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic [1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         clr,
  output logic [W-1:0] div_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (clr)     div_q <= '0;
    else if (tick_en) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CW   = 10,
  parameter int PER0 = 1024,
  parameter int PER1 = 16,
  parameter int PER2 = 64,
  parameter int PER3 = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic [1:0]    rate,
  output logic          step,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] lim;

  always_comb begin
    unique case (rate)
      2'd0:    lim = CW'(PER0 - 1);
      2'd1:    lim = CW'(PER1 - 1);
      2'd2:    lim = CW'(PER2 - 1);
      default: lim = CW'(PER3 - 1);
    endcase
  end

  assign step = tick_en && run && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (tick_en && run) cnt_q <= step ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr_cnt,
  input  logic         wr_mod,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] mod_q,
  output logic         ovf_q
);
  logic at_top;
  assign at_top = (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= step && !wr_cnt && at_top;
      if (wr_cnt)    cnt_q <= wdata;
      else if (step) cnt_q <= at_top ? mod_q : cnt_q + 1'b1;
      if (wr_mod)    mod_q <= wdata;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int W    = 8,
  parameter int PER0 = 1024,
  parameter int PER1 = 16,
  parameter int PER2 = 64,
  parameter int PER3 = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq_pulse
);
  import tmr_pkg::*;

  localparam int PMAX0 = (PER0 > PER1) ? PER0 : PER1;
  localparam int PMAX1 = (PER2 > PER3) ? PER2 : PER3;
  localparam int PMAX  = (PMAX0 > PMAX1) ? PMAX0 : PMAX1;
  localparam int CW    = (PMAX > 2) ? $clog2(PMAX) : 1;

  reg_sel_e      wsel, rsel;
  logic          wr_div, wr_cnt, wr_mod, wr_ctl;
  ctrl_t         ctl_q;
  logic          step;
  logic [CW-1:0] presc_q;
  logic [W-1:0]  div_q, cnt_q, mod_q;

  assign wsel   = reg_sel_e'(wr_addr);
  assign rsel   = reg_sel_e'(rd_addr);
  assign wr_div = wr_en && (wsel == SEL_DIV);
  assign wr_cnt = wr_en && (wsel == SEL_CNT);
  assign wr_mod = wr_en && (wsel == SEL_MOD);
  assign wr_ctl = wr_en && (wsel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctrl_t'(wr_data[2:0]);
  end

  tmr_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(wr_div), .div_q(div_q)
  );

  tmr_prescaler #(.CW(CW), .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(ctl_q.run),
    .rate(ctl_q.rate), .step(step), .cnt_q(presc_q)
  );

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_cnt(wr_cnt), .wr_mod(wr_mod),
    .wdata(wr_data), .cnt_q(cnt_q), .mod_q(mod_q), .ovf_q(irq_pulse)
  );

  always_comb begin
    unique case (rsel)
      SEL_DIV:  rd_data = div_q;
      SEL_CNT:  rd_data = cnt_q;
      SEL_MOD:  rd_data = mod_q;
      default:  rd_data = W'(ctl_q);
    endcase
  end
endmodule

// File: rtl/tick_timer_sva.sv
module tick_timer_sva #(
  parameter int W  = 8,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          irq_pulse,
  input logic [W-1:0]  div_q,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  mod_q,
  input logic [2:0]    ctl_bits,
  input logic [CW-1:0] presc_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_div_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && tick_en && !(wr_en && wr_addr == 2'd0)) |=> div_q == $past(div_q) + 1'b1);

  p_div_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en && wr_addr == 2'd0) |=> div_q == '0);

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ctl_bits[2] && !(wr_en && wr_addr == 2'd1)) |=> ($stable(cnt_q) && $stable(presc_q)));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && irq_pulse) |-> cnt_q == $past(mod_q));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en && wr_addr == 2'd1) |=> (cnt_q == $past(wr_data) && !irq_pulse));
endmodule

bind tick_timer tick_timer_sva #(.W(W), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq_pulse(irq_pulse), .div_q(div_q), .cnt_q(cnt_q),
  .mod_q(mod_q), .ctl_bits(ctl_q), .presc_q(presc_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq_pulse;

  int chk_cnt = 0;
  int fail_cnt = 0;
  int irq_cnt = 0;
  bit done = 0;

  // behavioural reference state
  int m_div = 0, m_cnt = 0, m_mod = 0, m_ctl = 0, m_pre = 0;
  bit m_irq = 0;

  always #2.5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  function automatic int period_of(int ctl);
    case (ctl & 3)
      0: return 1024;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_pre = 0; m_irq = 0;
    end else begin
      int o_mod, o_ctl;
      bit inc;
      o_mod = m_mod; o_ctl = m_ctl; inc = 0;
      if (wr_en && wr_addr == 0) m_div = 0;
      else if (tick_en) m_div = (m_div + 1) % 256;
      if (tick_en && (o_ctl & 4)) begin
        if (m_pre >= period_of(o_ctl) - 1) begin m_pre = 0; inc = 1; end
        else m_pre = m_pre + 1;
      end
      m_irq = 0;
      if (wr_en && wr_addr == 1) m_cnt = wr_data;
      else if (inc) begin
        if (m_cnt == 255) begin m_cnt = o_mod; m_irq = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (wr_en && wr_addr == 2) m_mod = wr_data;
      if (wr_en && wr_addr == 3) m_ctl = wr_data & 7;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int exp;
      string tag;
      if (irq_pulse) irq_cnt++;
      check(irq_pulse == m_irq, "R7 irq vs model", irq_pulse, m_irq);
      case (rd_addr)
        2'd0: begin exp = m_div; tag = "R2 divider vs model"; end
        2'd1: begin exp = m_cnt; tag = "R5 counter vs model"; end
        2'd2: begin exp = m_mod; tag = "R9 modulo vs model"; end
        default: begin exp = m_ctl; tag = "R9 control vs model"; end
      endcase
      check(rd_data == exp[7:0], tag, rd_data, exp);
    end
  end

  task automatic step(bit te, bit we, int a, int d);
    @(negedge clk);
    tick_en = te; wr_en = we; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    tick_en = 0; wr_en = 0; rd_addr = a[1:0];
    #1;
    check(rd_data == exp[7:0], tag, rd_data, exp);
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk_cnt++; fail_cnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int irq_before;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 0, "R1 divider reset");
    rd(1, 0, "R1 counter reset");
    rd(2, 0, "R1 modulo reset");
    rd(3, 0, "R1 control reset");
    check(irq_pulse == 0, "R1 irq reset", irq_pulse, 0);

    // 16-cycle rate, overflow after 32 ticks
    step(0, 1, 2, 8'h33);
    step(0, 1, 1, 8'hFE);
    step(0, 1, 0, 8'h00);
    step(0, 1, 3, 8'h05);
    rd(3, 5, "R9 control readback");
    irq_before = irq_cnt;
    run(16);
    rd(1, 8'hFF, "R5 one increment after 16 ticks");
    rd(0, 16, "R2 divider after 16 ticks");
    run(16);
    rd(1, 8'h33, "R7 reload from modulo");
    check(irq_cnt == irq_before + 1, "R7 one interrupt", irq_cnt - irq_before, 1);

    step(0, 1, 0, 8'hAB);
    rd(0, 0, "R3 divider cleared by write");

    step(0, 1, 3, 8'h01);
    run(100);
    rd(1, 8'h33, "R4 counter holds when disabled");

    step(0, 1, 3, 8'h04);
    run(1023);
    rd(1, 8'h33, "R5 no increment before 1024");
    run(1);
    rd(1, 8'h34, "R5 increment at 1024");

    run(40);
    step(0, 1, 3, 8'h05);
    step(0, 1, 0, 8'h00);
    run(1);
    rd(1, 8'h35, "R6 wrap after switch to shorter period");
    rd(3, 5, "R10 control write kept");

    // increment tick coincides with counter write
    run(15);
    irq_before = irq_cnt;
    step(1, 1, 1, 8'hFF);
    rd(1, 8'hFF, "R8 write wins over increment");
    check(irq_cnt == irq_before, "R8 no interrupt", irq_cnt - irq_before, 0);
    run(15);
    rd(1, 8'hFF, "R10 prescale kept its phase");
    run(1);
    rd(1, 8'h33, "R7 overflow after write");

    step(0, 1, 3, 8'hFF);
    rd(3, 7, "R9 control upper bits read zero");
    step(0, 1, 2, 8'hC4);
    rd(2, 8'hC4, "R9 modulo readback");

    step(0, 1, 0, 0);
    run(256);
    rd(0, 0, "R2 divider wraps at 256");

    // random phase, model compared every clock
    for (int i = 0; i < 6000; i++) begin
      int a, d, r;
      r = $urandom_range(0, 99);
      a = $urandom_range(0, 3);
      d = $urandom_range(0, 255);
      if (a == 3 && r < 80) d = 8'h05;
      if (a == 1 && r < 50) d = 8'hFD;
      @(negedge clk);
      tick_en = ($urandom_range(0, 9) != 0);
      wr_en = (r < 6);
      wr_addr = a[1:0];
      wr_data = d[7:0];
      rd_addr = $urandom_range(0, 3);
    end
    @(negedge clk);
    tick_en = 0; wr_en = 0;
    @(posedge clk);
    #2;
    finish_up();
  end
endmodule